// File: doc/BRIEF.md
# Protection-Key Access Permission Checker

This block decides whether a single memory access is blocked by a per-key rights policy. Every leaf page-table entry carries a 4-bit key, and a 32-bit rights register holds two control bits for each of the 16 keys. One bit blocks all data access through that key. The other bit blocks only writes. The block is given the leaf entry, the access kind, the privilege level, a paging-active flag and a control word that contains the feature enable bit. One cycle later it returns a verdict and, when the access is denied, a page-fault error code with the key-violation bit set.

Software reads and writes the rights register through a small register port. That port has a selector operand, and only selector value zero is accepted. Any other selector value is reported as an illegal operation and has no effect on the register. A write takes effect at the next clock edge. A check presented in the same cycle as a write is judged against the value the register held before the write.

Top module: `pkey_gate`

## Requirements
- R1: After synchronous reset, the rights register is all zeros, so every key has full access. `rsp_valid`, `rsp_deny`, `rsp_err`, `rr_done` and `rr_illegal` are all 0.
- R2: The key is `chk_pte[62:59]`. When rights bit 2·key (access-disable) is 1, a user-mode read (`chk_kind`=0) or write (`chk_kind`=1) is denied.
- R3: When rights bit 2·key+1 (write-disable) is 1 and the access-disable bit is 0, user-mode writes are denied and user-mode reads are allowed.
- R4: An instruction fetch (`chk_kind`=2) is never denied, whatever the rights bits are.
- R5: A supervisor-mode access (`chk_user`=0) is never denied.
- R6: When `chk_ctl[22]` is 0, every access is allowed.
- R7: When `chk_paging` is 0, every access is allowed, even if `chk_ctl[22]` is 1.
- R8: On a denied access, `rsp_err` has bit 0 = 1, bit 1 = 1 for a write and 0 for a read, bit 2 = 1 and bit 5 = 1, with all other bits 0. That gives 16'h0025 for a read and 16'h0027 for a write. On an allowed access, `rsp_err` is 0.
- R9: `rsp_valid` is 1 exactly one cycle after each cycle in which `chk_valid` is 1, and it carries that request's verdict. When `rsp_valid` is 0, `rsp_deny` and `rsp_err` are 0.
- R10: A read with `rr_sel`=0 puts the register value on `rr_rdata` one cycle later, with `rr_done`=1.
- R11: A read or write with `rr_sel`≠0 gives `rr_illegal`=1 one cycle later. It leaves both the rights register and `rr_rdata` unchanged.
- R12: A write with `rr_sel`=0 updates the register at the next edge. A check issued in the same cycle as the write uses the old value. A read issued in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_rd_en | input | 1 | Rights register read request |
| rr_wr_en | input | 1 | Rights register write request |
| rr_sel | input | 32 | Selector operand; only 0 is legal |
| rr_wdata | input | 32 | Rights register write value |
| rr_rdata | output | 32 | Value returned by the last legal read |
| rr_done | output | 1 | Pulse: a legal register operation completed |
| rr_illegal | output | 1 | Pulse: a register operation used a non-zero selector |
| chk_valid | input | 1 | Check request strobe |
| chk_pte | input | 64 | Leaf page-table entry for the access |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| chk_user | input | 1 | 1 for a user-mode access |
| chk_paging | input | 1 | 1 when paging is active |
| chk_ctl | input | 32 | Control word; bit 22 enables key checks |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_deny | output | 1 | 1 when the access is denied |
| rsp_err | output | 16 | Page-fault error code for a denial |

## Verification
The rights register can only be seen through checks and legal reads. A corrupted pair of bits therefore shows up as a wrong verdict for that key, or as a wrong read value, on the first response after the bad state appears. To catch this, the bench sets each key in isolation and sweeps across all of them, so a mis-indexed or swapped pair denies the wrong key within one cycle. Gating faults (enable, paging, privilege or fetch) give a denial where an allow is expected, in the response that directly follows the request. Write-ordering faults are caught by issuing a write and a check in the same cycle.

// File: rtl/pkey_gate_pkg.sv
package pkey_gate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int ERR_P_BIT  = 0;
    localparam int ERR_WR_BIT = 1;
    localparam int ERR_U_BIT  = 2;
    localparam int ERR_PK_BIT = 5;

    typedef struct packed {
        logic      gate_on;
        logic      user;
        acc_kind_e kind;
    } chk_ctx_t;

    typedef struct packed {
        logic deny;
        logic is_write;
    } verdict_t;

    function automatic logic kind_is_data(acc_kind_e k);
        return (k == ACC_READ) || (k == ACC_WRITE);
    endfunction

endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
    parameter int W     = 32,
    parameter int SEL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rights,
    output logic [W-1:0]     rdata,
    output logic             done,
    output logic             illegal
);

    logic sel_ok;
    logic any_op;

    assign sel_ok = (sel == '0);
    assign any_op = rd_en | wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rights  <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= any_op & sel_ok;
            illegal <= any_op & ~sel_ok;
            if (rd_en && sel_ok) begin
                rdata <= rights;
            end
            if (wr_en && sel_ok) begin
                rights <= wdata;
            end
        end
    end

endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
    import pkey_gate_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic [2*(2**KEY_W)-1:0] rights,
    input  logic [KEY_W-1:0]        key,
    input  chk_ctx_t                ctx,
    output verdict_t                verdict
);

    localparam int NKEYS = 2**KEY_W;

    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    for (genvar g = 0; g < NKEYS; g++) begin : g_split
        assign ad_vec[g] = rights[2*g];
        assign wd_vec[g] = rights[2*g+1];
    end

    logic ad_hit;
    logic wd_hit;
    logic wr;

    always_comb begin
        ad_hit = ad_vec[key];
        wd_hit = wd_vec[key];
        wr     = (ctx.kind == ACC_WRITE);
        verdict.is_write = wr;
        verdict.deny     = 1'b0;
        if (ctx.gate_on && ctx.user && kind_is_data(ctx.kind)) begin
            verdict.deny = ad_hit | (wd_hit & wr);
        end
    end

endmodule

// File: rtl/pkey_gate.sv
module pkey_gate
    import pkey_gate_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int KEY_LSB = 59,
    parameter int KEY_W   = 4,
    parameter int CTL_W   = 32,
    parameter int EN_BIT  = 22,
    parameter int SEL_W   = 32,
    parameter int ERR_W   = 16,
    localparam int NKEYS    = 2**KEY_W,
    localparam int RIGHTS_W = 2*NKEYS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rr_rd_en,
    input  logic                rr_wr_en,
    input  logic [SEL_W-1:0]    rr_sel,
    input  logic [RIGHTS_W-1:0] rr_wdata,
    output logic [RIGHTS_W-1:0] rr_rdata,
    output logic                rr_done,
    output logic                rr_illegal,
    input  logic                chk_valid,
    input  logic [PTE_W-1:0]    chk_pte,
    input  logic [1:0]          chk_kind,
    input  logic                chk_user,
    input  logic                chk_paging,
    input  logic [CTL_W-1:0]    chk_ctl,
    output logic                rsp_valid,
    output logic                rsp_deny,
    output logic [ERR_W-1:0]    rsp_err
);

    logic [RIGHTS_W-1:0] rights_q;

    pkey_rights_reg #(
        .W     (RIGHTS_W),
        .SEL_W (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rr_rd_en),
        .wr_en   (rr_wr_en),
        .sel     (rr_sel),
        .wdata   (rr_wdata),
        .rights  (rights_q),
        .rdata   (rr_rdata),
        .done    (rr_done),
        .illegal (rr_illegal)
    );

    logic [KEY_W-1:0] key;
    chk_ctx_t         ctx;
    verdict_t         verdict;
    logic             field_unused;

    assign key          = chk_pte[KEY_LSB +: KEY_W];
    assign ctx.gate_on  = chk_paging & chk_ctl[EN_BIT];
    assign ctx.user     = chk_user;
    assign ctx.kind     = acc_kind_e'(chk_kind);
    assign field_unused = ^{chk_pte[PTE_W-1:KEY_LSB+KEY_W], chk_pte[KEY_LSB-1:0],
                            chk_ctl[CTL_W-1:EN_BIT+1], chk_ctl[EN_BIT-1:0]};

    pkey_decide #(
        .KEY_W (KEY_W)
    ) u_decide (
        .rights  (rights_q),
        .key     (key),
        .ctx     (ctx),
        .verdict (verdict)
    );

    logic [ERR_W-1:0] err_d;

    always_comb begin
        err_d = '0;
        if (verdict.deny) begin
            err_d[ERR_P_BIT]  = 1'b1;
            err_d[ERR_WR_BIT] = verdict.is_write;
            err_d[ERR_U_BIT]  = 1'b1;
            err_d[ERR_PK_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_deny  <= 1'b0;
            rsp_err   <= '0;
        end else begin
            rsp_valid <= chk_valid;
            rsp_deny  <= chk_valid & verdict.deny;
            rsp_err   <= chk_valid ? err_d : '0;
        end
    end

endmodule

// File: rtl/pkey_gate_chk.sv
module pkey_gate_chk #(
    parameter int CTL_W    = 32,
    parameter int EN_BIT   = 22,
    parameter int SEL_W    = 32,
    parameter int ERR_W    = 16,
    parameter int RIGHTS_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                rr_rd_en,
    input logic                rr_wr_en,
    input logic [SEL_W-1:0]    rr_sel,
    input logic [RIGHTS_W-1:0] rr_wdata,
    input logic                rr_illegal,
    input logic [RIGHTS_W-1:0] rights,
    input logic                chk_valid,
    input logic [1:0]          chk_kind,
    input logic                chk_user,
    input logic                chk_paging,
    input logic [CTL_W-1:0]    chk_ctl,
    input logic                rsp_valid,
    input logic                rsp_deny,
    input logic [ERR_W-1:0]    rsp_err
);

    // R9
    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);
    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_deny && rsp_err == '0));

    // R8
    p_err_fields_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_deny) |-> (rsp_err[5] && rsp_err[2] && rsp_err[0]));
    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_deny) |-> (rsp_err == '0));

    // R4
    p_fetch_allowed_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_kind == 2'd2) |=> !rsp_deny);
    // R5
    p_super_allowed_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_user) |=> !rsp_deny);
    // R6
    p_disabled_allowed_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_ctl[EN_BIT]) |=> !rsp_deny);
    // R7
    p_nopaging_allowed_r7: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_paging) |=> !rsp_deny);

    // R11
    p_bad_sel_flag_r11: assert property (@(posedge clk) disable iff (rst)
        ((rr_rd_en || rr_wr_en) && rr_sel != '0) |=> rr_illegal);
    p_good_sel_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !((rr_rd_en || rr_wr_en) && rr_sel != '0) |=> !rr_illegal);
    p_rights_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(rr_wr_en && rr_sel == '0) |=> $stable(rights));

    // R12
    p_write_lands_r12: assert property (@(posedge clk) disable iff (rst)
        (rr_wr_en && rr_sel == '0) |=> (rights == $past(rr_wdata)));

endmodule

bind pkey_gate pkey_gate_chk #(
    .CTL_W    (CTL_W),
    .EN_BIT   (EN_BIT),
    .SEL_W    (SEL_W),
    .ERR_W    (ERR_W),
    .RIGHTS_W (RIGHTS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rr_rd_en   (rr_rd_en),
    .rr_wr_en   (rr_wr_en),
    .rr_sel     (rr_sel),
    .rr_wdata   (rr_wdata),
    .rr_illegal (rr_illegal),
    .rights     (rights_q),
    .chk_valid  (chk_valid),
    .chk_kind   (chk_kind),
    .chk_user   (chk_user),
    .chk_paging (chk_paging),
    .chk_ctl    (chk_ctl),
    .rsp_valid  (rsp_valid),
    .rsp_deny   (rsp_deny),
    .rsp_err    (rsp_err)
);

// File: tb/tb_pkey_gate.sv
`timescale 1ns/1ps
module tb_pkey_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rr_rd_en = 1'b0;
    logic        rr_wr_en = 1'b0;
    logic [31:0] rr_sel = '0;
    logic [31:0] rr_wdata = '0;
    logic [31:0] rr_rdata;
    logic        rr_done;
    logic        rr_illegal;
    logic        chk_valid = 1'b0;
    logic [63:0] chk_pte = '0;
    logic [1:0]  chk_kind = '0;
    logic        chk_user = 1'b0;
    logic        chk_paging = 1'b0;
    logic [31:0] chk_ctl = '0;
    logic        rsp_valid;
    logic        rsp_deny;
    logic [15:0] rsp_err;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_rights = '0;
    localparam logic [31:0] CTL_ON = 32'h0040_0000;

    always #2 clk = ~clk;

    pkey_gate dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_err(input logic [3:0] k, input logic [1:0] kind,
                                            input logic user, input logic pg, input logic [31:0] ctl,
                                            input logic [31:0] r);
        logic dn;
        dn = 1'b0;
        if (pg && ctl[22] && user && kind != 2'd2) dn = r[2*k] | (r[2*k+1] & (kind == 2'd1));
        return dn ? (kind == 2'd1 ? 16'h0027 : 16'h0025) : 16'h0000;
    endfunction

    function automatic logic [63:0] mk_pte(input logic [3:0] k);
        return 64'h8000_0000_0000_0067 | (64'(k) << 59);
    endfunction

    task automatic do_check(input logic [3:0] k, input logic [1:0] kind, input logic user,
                            input logic pg, input logic [31:0] ctl, input string req);
        logic [15:0] e;
        @(negedge clk);
        chk_valid = 1'b1; chk_pte = mk_pte(k); chk_kind = kind;
        chk_user = user; chk_paging = pg; chk_ctl = ctl;
        e = exp_err(k, kind, user, pg, ctl, m_rights);
        @(posedge clk); #1;
        chk_valid = 1'b0;
        chk(rsp_valid == 1'b1, req, 64'(rsp_valid), 64'd1);
        chk(rsp_deny == (e != 0), req, 64'(rsp_deny), 64'(e != 0));
        chk(rsp_err == e, req, 64'(rsp_err), 64'(e));
    endtask

    task automatic rr_op(input logic rd, input logic wr, input logic [31:0] sel, input logic [31:0] d);
        @(negedge clk);
        rr_rd_en = rd; rr_wr_en = wr; rr_sel = sel; rr_wdata = d;
        @(posedge clk); #1;
        rr_rd_en = 1'b0; rr_wr_en = 1'b0;
        if (wr && sel == 0) m_rights = d;
    endtask

    task automatic t_reset();
        chk(rsp_valid == 0 && rsp_deny == 0 && rsp_err == 0, "R1 rsp idle", 64'(rsp_err), 0);
        chk(rr_done == 0 && rr_illegal == 0, "R1 rr flags", 64'({rr_done, rr_illegal}), 0);
        rr_op(1'b1, 1'b0, 32'd0, '0);
        chk(rr_rdata == 32'h0 && rr_done, "R1 rights zero", 64'(rr_rdata), 0);
        do_check(4'd3, 2'd1, 1'b1, 1'b1, CTL_ON, "R1 full access");
    endtask

    task automatic t_access_disable();
        for (int k = 0; k < 16; k++) begin
            rr_op(1'b0, 1'b1, 32'd0, 32'h1 << (2*k));
            do_check(4'(k), 2'd0, 1'b1, 1'b1, CTL_ON, "R2 AD read deny");
            do_check(4'(k), 2'd1, 1'b1, 1'b1, CTL_ON, "R2 AD write deny R8");
            do_check(4'(k ^ 1), 2'd0, 1'b1, 1'b1, CTL_ON, "R2 other key allowed");
        end
    endtask

    task automatic t_write_disable();
        for (int k = 0; k < 16; k += 5) begin
            rr_op(1'b0, 1'b1, 32'd0, 32'h2 << (2*k));
            do_check(4'(k), 2'd0, 1'b1, 1'b1, CTL_ON, "R3 WD read allowed");
            do_check(4'(k), 2'd1, 1'b1, 1'b1, CTL_ON, "R3 WD write deny R8");
        end
    endtask

    task automatic t_gates();
        rr_op(1'b0, 1'b1, 32'd0, 32'hFFFF_FFFF);
        do_check(4'd7, 2'd2, 1'b1, 1'b1, CTL_ON, "R4 fetch allowed");
        do_check(4'd7, 2'd1, 1'b0, 1'b1, CTL_ON, "R5 supervisor write allowed");
        do_check(4'd7, 2'd0, 1'b0, 1'b1, CTL_ON, "R5 supervisor read allowed");
        do_check(4'd7, 2'd1, 1'b1, 1'b1, ~CTL_ON, "R6 disabled allowed");
        do_check(4'd7, 2'd1, 1'b1, 1'b0, CTL_ON, "R7 no paging allowed");
        do_check(4'd7, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 read code");
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(posedge clk); #1;
        chk(rsp_valid == 0 && rsp_deny == 0 && rsp_err == 0, "R9 no response when idle",
            64'({rsp_valid, rsp_deny}), 0);
    endtask

    task automatic t_regs();
        rr_op(1'b0, 1'b1, 32'd0, 32'hA5A5_0F0F);
        rr_op(1'b1, 1'b0, 32'd0, '0);
        chk(rr_rdata == 32'hA5A5_0F0F && rr_done, "R10 legal read", 64'(rr_rdata), 64'hA5A5_0F0F);
        rr_op(1'b0, 1'b1, 32'd1, 32'h1234_5678);
        chk(rr_illegal && !rr_done, "R11 write bad sel flag", 64'(rr_illegal), 1);
        rr_op(1'b1, 1'b0, 32'h8000_0000, '0);
        chk(rr_illegal, "R11 read bad sel flag", 64'(rr_illegal), 1);
        chk(rr_rdata == 32'hA5A5_0F0F, "R11 rdata kept", 64'(rr_rdata), 64'hA5A5_0F0F);
        rr_op(1'b1, 1'b0, 32'd0, '0);
        chk(rr_rdata == 32'hA5A5_0F0F && !rr_illegal, "R11 rights unchanged", 64'(rr_rdata), 64'hA5A5_0F0F);
    endtask

    task automatic t_write_order();
        rr_op(1'b0, 1'b1, 32'd0, 32'h0);
        @(negedge clk);
        rr_wr_en = 1'b1; rr_rd_en = 1'b1; rr_sel = '0; rr_wdata = 32'h0000_0001;
        chk_valid = 1'b1; chk_pte = mk_pte(4'd0); chk_kind = 2'd0;
        chk_user = 1'b1; chk_paging = 1'b1; chk_ctl = CTL_ON;
        @(posedge clk); #1;
        rr_wr_en = 1'b0; rr_rd_en = 1'b0; chk_valid = 1'b0;
        chk(rsp_valid && !rsp_deny, "R12 same-cycle check uses old", 64'(rsp_deny), 0);
        chk(rr_rdata == 32'h0, "R12 same-cycle read old", 64'(rr_rdata), 0);
        m_rights = 32'h1;
        do_check(4'd0, 2'd0, 1'b1, 1'b1, CTL_ON, "R12 next check uses new");
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_access_disable();
        t_write_disable();
        t_gates();
        t_idle();
        t_regs();
        t_write_order();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule